// File: doc/BRIEF.md
# Compare Flags and Branch Decision Unit

This block sits beside the execute stage of a small 32-bit core and serves two instruction kinds. A compare instruction loads a three-bit status register. The register marks whether the first operand is equal to, greater than or less than the second, with both operands read as signed two's complement values. A conditional or unconditional jump reads the stored status in the same cycle it is presented and raises a taken indication. In that cycle the block also forms the jump target address.

There are three ways to form the target. The first adds a sign-extended 16-bit byte offset to the current program counter. The second adds the same offset to a register value, for example a saved return address. The third builds an absolute word-aligned address from a 26-bit field and the top bits of the program counter. A separate mode input selects the target form. The fetch logic consumes `taken_o` and `target_o`; redirection and flushing are handled outside this block.

Top module: `branch_cond_unit`

## Requirements
- R1: When `op_i` is 0x14, the flags on `flags_o` reflect the signed comparison of `opa_i` against `opb_i` from the next rising clock edge. The bit positions are: bit 0 equal, bit 1 greater, bit 2 less.
- R2: After any compare, exactly one of the three flag bits is set.
- R3: Any opcode other than 0x14 leaves `flags_o` unchanged.
- R4: While `rst_n` is low, all three flags are cleared.
- R5: Opcode 0x0D always raises `taken_o`. The other jump opcodes raise it in the same cycle from the stored flags, as follows:
  - 0x0E: equal is set.
  - 0x0F: equal is clear.
  - 0x10: greater is set.
  - 0x11: greater or equal is set.
  - 0x12: less is set.
  - 0x13: less or equal is set.
- R6: Every opcode outside 0x0D to 0x13 holds `taken_o` low.
- R7: When `tgt_mode_i` is 0, `target_o` equals `pc_i` plus `imm_i` sign-extended to 32 bits, with the sum wrapping modulo 2^32.
- R8: When `tgt_mode_i` is 1, `target_o` equals `opa_i` plus `imm_i` sign-extended to 32 bits, with the sum wrapping modulo 2^32.
- R9: When `tgt_mode_i` is 2 or 3, `target_o` is formed from three parts. Bits 31:28 are `pc_i[31:28]`, bits 27:2 are `jaddr_i`, and bits 1:0 are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 6 | Instruction opcode |
| opa_i | input | 32 | First register operand, also the base for register-relative targets |
| opb_i | input | 32 | Second register operand |
| imm_i | input | 16 | Signed byte offset |
| jaddr_i | input | 26 | Word index for absolute targets |
| pc_i | input | 32 | Current program counter |
| tgt_mode_i | input | 2 | Target form: 0 PC-relative, 1 register-relative, 2 or 3 absolute |
| taken_o | output | 1 | Jump is taken this cycle |
| target_o | output | 32 | Jump target address |
| flags_o | output | 3 | Status flags {less, greater, equal} |

## Verification
The flag results come from a register, so they appear one rising edge after the compare is presented. `taken_o` and `target_o` are combinational and are due in the same cycle as their inputs. The bench applies each input set on the falling edge and samples a quarter period later, before the next rising edge. Its reference model commits the new flags only after that sample. A jump placed directly after a compare is therefore checked against the flags that compare produced, and never against flags still pending.

// File: rtl/bcu_pkg.sv
package bcu_pkg;

    localparam int OP_W = 6;

    localparam logic [OP_W-1:0] OP_CMP  = 6'h14;
    localparam logic [OP_W-1:0] OP_JMP0 = 6'h0D;  // first of the jump opcodes
    localparam int              N_COND  = 7;      // jump opcodes 0x0D..0x13

    typedef struct packed {
        logic lt;   // bit 2
        logic gt;   // bit 1
        logic eq;   // bit 0
    } flags_t;

    typedef enum logic [1:0] {
        TGT_PCREL = 2'd0,
        TGT_REGREL = 2'd1,
        TGT_ABS_A = 2'd2,
        TGT_ABS_B = 2'd3
    } tgt_mode_e;

    // condition test for jump opcode index i (0 = unconditional)
    function automatic logic cond_met(input int idx, input flags_t f);
        case (idx)
            0:       cond_met = 1'b1;
            1:       cond_met = f.eq;
            2:       cond_met = !f.eq;
            3:       cond_met = f.gt;
            4:       cond_met = f.gt | f.eq;
            5:       cond_met = f.lt;
            6:       cond_met = f.lt | f.eq;
            default: cond_met = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/bcu_compare.sv
module bcu_compare
    import bcu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    output flags_t          res_o
);

    logic signed [XLEN-1:0] sa;
    logic signed [XLEN-1:0] sb;

    always_comb begin
        sa        = signed'(a_i);
        sb        = signed'(b_i);
        res_o.eq  = (sa == sb);
        res_o.gt  = (sa > sb);
        res_o.lt  = (sa < sb);
    end

endmodule

// File: rtl/bcu_cond_eval.sv
module bcu_cond_eval
    import bcu_pkg::*;
(
    input  logic [OP_W-1:0] op_i,
    input  flags_t          flags_i,
    output logic            taken_o
);

    logic [N_COND-1:0] hit;

    for (genvar i = 0; i < N_COND; i++) begin : g_cond
        localparam logic [OP_W-1:0] CODE = OP_W'(int'(OP_JMP0) + i);
        assign hit[i] = (op_i == CODE) && cond_met(i, flags_i);
    end

    assign taken_o = |hit;

endmodule

// File: rtl/bcu_target_gen.sv
module bcu_target_gen
    import bcu_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int IMM_W   = 16,
    parameter int JADDR_W = 26
) (
    input  logic [1:0]         mode_i,
    input  logic [XLEN-1:0]    pc_i,
    input  logic [XLEN-1:0]    base_i,
    input  logic [IMM_W-1:0]   imm_i,
    input  logic [JADDR_W-1:0] jaddr_i,
    output logic [XLEN-1:0]    target_o
);

    localparam int HI_W = XLEN - JADDR_W - 2;

    logic [XLEN-1:0] simm;
    logic [XLEN-1:0] abs_tgt;
    logic [XLEN-1:0] rel_base;

    assign simm = {{(XLEN-IMM_W){imm_i[IMM_W-1]}}, imm_i};

    if (HI_W > 0) begin : g_hi
        assign abs_tgt = {pc_i[XLEN-1 -: HI_W], jaddr_i, 2'b00};
    end else begin : g_nohi
        assign abs_tgt = {jaddr_i[XLEN-3:0], 2'b00};
    end

    always_comb begin
        rel_base = (mode_i == TGT_REGREL) ? base_i : pc_i;
        if (mode_i[1]) target_o = abs_tgt;
        else           target_o = rel_base + simm;
    end

endmodule

// File: rtl/branch_cond_unit.sv
module branch_cond_unit
    import bcu_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int IMM_W   = 16,
    parameter int JADDR_W = 26
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [OP_W-1:0]    op_i,
    input  logic [XLEN-1:0]    opa_i,
    input  logic [XLEN-1:0]    opb_i,
    input  logic [IMM_W-1:0]   imm_i,
    input  logic [JADDR_W-1:0] jaddr_i,
    input  logic [XLEN-1:0]    pc_i,
    input  logic [1:0]         tgt_mode_i,
    output logic               taken_o,
    output logic [XLEN-1:0]    target_o,
    output logic [2:0]         flags_o
);

    typedef struct packed {
        flags_t flags;
    } state_t;

    state_t st_d;
    state_t st_q;
    flags_t cmp_res;

    bcu_compare #(.XLEN(XLEN)) u_cmp (
        .a_i   (opa_i),
        .b_i   (opb_i),
        .res_o (cmp_res)
    );

    always_comb begin
        st_d = st_q;
        if (op_i == OP_CMP) st_d.flags = cmp_res;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    bcu_cond_eval u_cond (
        .op_i    (op_i),
        .flags_i (st_q.flags),
        .taken_o (taken_o)
    );

    bcu_target_gen #(
        .XLEN    (XLEN),
        .IMM_W   (IMM_W),
        .JADDR_W (JADDR_W)
    ) u_tgt (
        .mode_i   (tgt_mode_i),
        .pc_i     (pc_i),
        .base_i   (opa_i),
        .imm_i    (imm_i),
        .jaddr_i  (jaddr_i),
        .target_o (target_o)
    );

    assign flags_o = st_q.flags;

endmodule

// File: rtl/bcu_checker.sv
module bcu_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [5:0]  op_i,
    input logic [1:0]  tgt_mode_i,
    input logic [31:0] pc_i,
    input logic        taken_o,
    input logic [31:0] target_o,
    input logic [2:0]  flags_o
);

    a_r4_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (flags_o == 3'b000));

    a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 6'h14) |=> ($countones(flags_o) == 1));

    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i != 6'h14) |=> $stable(flags_o));

    a_r5_uncond: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 6'h0D) |-> taken_o);

    a_r6_nonjump: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_i < 6'h0D) || (op_i > 6'h13)) |-> !taken_o);

    a_r9_abs_form: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_mode_i[1] |-> ((target_o[31:28] == pc_i[31:28]) && (target_o[1:0] == 2'b00)));

endmodule

bind branch_cond_unit bcu_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_i       (op_i),
    .tgt_mode_i (tgt_mode_i),
    .pc_i       (pc_i),
    .taken_o    (taken_o),
    .target_o   (target_o),
    .flags_o    (flags_o)
);

// File: tb/sim_branch_cond_unit.sv
module sim_branch_cond_unit;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  op = 6'h00;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic [15:0] imm = '0;
    logic [25:0] jaddr = '0;
    logic [31:0] pc = '0;
    logic [1:0]  mode = 2'd0;
    logic        taken;
    logic [31:0] target;
    logic [2:0]  flags;

    int n_chk = 0;
    int n_fail = 0;
    logic [2:0] m_flags = 3'b000;   // model: {lt, gt, eq}

    always #(CLK_PERIOD/2) clk = ~clk;

    branch_cond_unit u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_i       (op),
        .opa_i      (opa),
        .opb_i      (opb),
        .imm_i      (imm),
        .jaddr_i    (jaddr),
        .pc_i       (pc),
        .tgt_mode_i (mode),
        .taken_o    (taken),
        .target_o   (target),
        .flags_o    (flags)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic exp_taken(input logic [5:0] o, input logic [2:0] f);
        case (o)
            6'h0D: return 1'b1;
            6'h0E: return f[0];
            6'h0F: return !f[0];
            6'h10: return f[1];
            6'h11: return f[1] | f[0];
            6'h12: return f[2];
            6'h13: return f[2] | f[0];
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] exp_target(input logic [1:0] md, input logic [31:0] p,
            input logic [31:0] a, input logic [15:0] im, input logic [25:0] ja);
        longint s;
        s = longint'($signed(im));
        if (md >= 2) return {p[31:28], ja, 2'b00};
        if (md == 1) return 32'(longint'(a) + s);
        return 32'(longint'(p) + s);
    endfunction

    // one cycle: drive on falling edge, sample a quarter period later, then commit model
    task automatic step(input logic [5:0] o, input logic [31:0] a, input logic [31:0] b,
                        input logic [15:0] im, input logic [25:0] ja, input logic [31:0] p,
                        input logic [1:0] md);
        logic [2:0] nf;
        logic        et;
        logic [31:0] etg;
        @(negedge clk);
        op = o; opa = a; opb = b; imm = im; jaddr = ja; pc = p; mode = md;
        #(CLK_PERIOD/4);
        check(flags == m_flags, "R1/R3 flags", {29'd0, flags}, {29'd0, m_flags});
        et = exp_taken(o, m_flags);
        check(taken == et, (o >= 6'h0D && o <= 6'h13) ? "R5 taken" : "R6 taken",
              {31'd0, taken}, {31'd0, et});
        etg = exp_target(md, p, a, im, ja);
        check(target == etg, md >= 2 ? "R9 target" : (md == 1 ? "R8 target" : "R7 target"),
              target, etg);
        if (o == 6'h14) begin
            nf = ($signed(a) == $signed(b)) ? 3'b001 :
                 ($signed(a) >  $signed(b)) ? 3'b010 : 3'b100;
            m_flags = nf;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        // R4: reset state, even with a compare presented
        op = 6'h14; opa = 32'd5; opb = 32'd1;
        repeat (3) @(posedge clk);
        #1;
        check(flags == 3'b000, "R4 reset flags", {29'd0, flags}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        op = 6'h00;

        // after reset: all flags clear, so 0x0F taken and 0x0E not
        step(6'h0F, 0, 0, 16'h0010, 0, 32'h1000, 2'd0);
        step(6'h0E, 0, 0, 16'hFFF0, 0, 32'h1000, 2'd0);

        // R1: signed corners
        step(6'h14, 32'h8000_0000, 32'h0000_0001, 0, 0, 0, 0);  // less
        check(flags == 3'b000, "R1 flags not yet updated", {29'd0, flags}, 32'd0);
        step(6'h12, 0, 0, 16'h0004, 0, 32'h2000, 2'd0);         // R5 JLT taken
        step(6'h10, 0, 0, 16'h0004, 0, 32'h2000, 2'd0);         // R5 JGT not taken
        step(6'h14, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 0, 0, 0, 0);  // greater
        step(6'h11, 0, 0, 0, 0, 0, 0);
        step(6'h13, 0, 0, 0, 0, 0, 0);
        step(6'h14, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 0, 0, 0, 0);  // equal
        check($countones(flags) == 1, "R2 one flag", {29'd0, flags}, 32'd1);
        step(6'h11, 0, 0, 0, 0, 0, 0);
        step(6'h13, 0, 0, 0, 0, 0, 0);

        // R3: non-compare opcodes with differing operands leave flags
        step(6'h19, 32'd1, 32'd9, 0, 0, 0, 0);
        step(6'h00, 32'd9, 32'd1, 0, 0, 0, 0);

        // R6: non-jump opcodes adjacent to the range
        step(6'h0C, 0, 0, 0, 0, 0, 0);
        step(6'h14, 32'd3, 32'd3, 0, 0, 0, 0);
        step(6'h3F, 0, 0, 0, 0, 0, 0);

        // R7/R8/R9: target forms with wrap and negative offsets
        step(6'h0D, 32'h0000_0004, 0, 16'h8000, 0, 32'h0000_0010, 2'd0);
        step(6'h0D, 32'hFFFF_FFFC, 0, 16'h0008, 0, 32'h0, 2'd1);
        step(6'h0D, 32'h0000_0100, 0, 16'h0004, 0, 32'h0, 2'd1);
        step(6'h0D, 0, 0, 0, 26'h3FF_FFFF, 32'hA123_4567, 2'd2);
        step(6'h0D, 0, 0, 0, 26'h000_0001, 32'h5FFF_FFFF, 2'd3);

        // random mix, compares frequent
        for (int i = 0; i < 3000; i++) begin
            logic [5:0] ro;
            logic [31:0] ra, rb;
            case ($urandom_range(0, 3))
                0: ro = 6'h14;
                1: ro = 6'(6'h0D + $urandom_range(0, 6));
                default: ro = 6'($urandom_range(0, 63));
            endcase
            ra = $urandom;
            rb = ($urandom_range(0, 3) == 0) ? ra : 32'($urandom);
            step(ro, ra, rb, 16'($urandom), 26'($urandom), 32'($urandom), 2'($urandom_range(0, 3)));
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule